// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block is the device side of a 16-bit parallel NOR flash, modelled as synchronous logic. The host performs single-cycle write and read strobes. Writes are not stored directly. They are fed into a tracker that only acts on complete unlock sequences. These are two fixed unlock writes, a command write, and for erases a second unlock pair with a final command. Recognised commands are word program, sector erase, whole-array erase, and entry to and exit from identification mode.

A started operation occupies the device for a number of clock cycles set by parameters. During that time every read returns a status word instead of array data, and the host polls it until two consecutive reads agree. An erase sweeps one word per cycle through the affected range and writes all ones. A program can only clear bits. Erase units are 4 KB sectors of 16-bit words, and the sector count is a parameter.

Top module: `nor_flash_cmd`

## Requirements
- R1: After reset, rdata_o is 0x0000. A read strobe on re_i returns its data on rdata_o in the following cycle.
- R2: The writes 0x00AA@0x5555, 0x0055@0x2AAA and 0x00A0@0x5555, followed by any write (addr, data), program the word at addr.
- R3: A program stores the bitwise AND of the old word and the written data, so no bit can go from 0 to 1.
- R4: The unlock pair, 0x0080@0x5555, a second unlock pair, then 0x0030 written at any address in a sector sets every word of that sector to 0xFFFF. Other sectors are left untouched.
- R5: The same prefix ending in 0x0010@0x5555 sets every word of the array to 0xFFFF.
- R6: While wp_ni is low, the whole-array erase sequence starts nothing: the next read returns array data.
- R7: From the first read after the final command write until the operation ends, reads return a word in which only bits 6 and 2 may be set. Bit 6 inverts on every read.
- R8: Bit 2 of the status inverts on every read during an erase and stays constant during a program.
- R9: Writes that arrive while an operation is running are ignored, including complete command sequences.
- R10: Any write that does not match the next expected address/data pair returns the tracker to idle. The sequence must then restart from its first write.
- R11: After the unlock pair and 0x0090@0x5555, address 0 reads 0x00BF and address 1 reads DEV_ID. The unlock pair and 0x00F0@0x5555 return to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Single-cycle write strobe |
| re_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| wp_ni | input | 1 | Write protect, active low, blocks array erase |
| rdata_o | output | 16 | Read data, valid the cycle after re_i |

## Verification
The bench reads the status on the cycle right after the last command write. A design that raised busy one cycle late would return array data there. Bit 2 is compared across consecutive reads in both program and erase, which catches a status path that toggles both bits regardless of the operation. A complete program sequence is written into the middle of an erase, and two broken sequences are followed by plain writes. A tracker that buffered writes while busy, or fell back to a partial state instead of idle, would corrupt a word that the bench's model keeps unchanged. Full-array readback after both erase types exposes a sweep that stops one word short or crosses a sector boundary.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E1, SQ_E2, SQ_E3
  } seq_st_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_PROG, OP_SECT, OP_CHIP
  } op_e;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;

  localparam logic [15:0] CMD_AA = 16'h00AA;
  localparam logic [15:0] CMD_55 = 16'h0055;
  localparam logic [15:0] CMD_PG = 16'h00A0;
  localparam logic [15:0] CMD_ER = 16'h0080;
  localparam logic [15:0] CMD_SE = 16'h0030;
  localparam logic [15:0] CMD_CE = 16'h0010;
  localparam logic [15:0] CMD_ID = 16'h0090;
  localparam logic [15:0] CMD_EX = 16'h00F0;

  localparam logic [15:0] MFR_CODE = 16'h00BF;

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IW     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              wp_ni,
  output logic              start_o,
  output op_e               op_o,
  output logic [IW-1:0]     op_addr_o,
  output logic [15:0]       op_data_o,
  output logic              id_enter_o,
  output logic              id_exit_o
);

  seq_st_e st_q;
  logic    at_a, at_b;

  assign at_a = (addr_i == ADDR_W'(UNLOCK_A));
  assign at_b = (addr_i == ADDR_W'(UNLOCK_B));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_IDLE;
      start_o    <= 1'b0;
      op_o       <= OP_NONE;
      op_addr_o  <= '0;
      op_data_o  <= '0;
      id_enter_o <= 1'b0;
      id_exit_o  <= 1'b0;
    end else begin
      start_o    <= 1'b0;
      id_enter_o <= 1'b0;
      id_exit_o  <= 1'b0;
      if (wr_i) begin
        unique case (st_q)
          SQ_IDLE: st_q <= (at_a && data_i == CMD_AA) ? SQ_U1 : SQ_IDLE;
          SQ_U1:   st_q <= (at_b && data_i == CMD_55) ? SQ_U2 : SQ_IDLE;
          SQ_U2: begin
            st_q <= SQ_IDLE;
            if (at_a) begin
              case (data_i)
                CMD_PG:  st_q <= SQ_PROG;
                CMD_ER:  st_q <= SQ_E1;
                CMD_ID:  id_enter_o <= 1'b1;
                CMD_EX:  id_exit_o  <= 1'b1;
                default: ;
              endcase
            end
          end
          SQ_PROG: begin
            st_q      <= SQ_IDLE;
            start_o   <= 1'b1;
            op_o      <= OP_PROG;
            op_addr_o <= addr_i[IW-1:0];
            op_data_o <= data_i;
          end
          SQ_E1: st_q <= (at_a && data_i == CMD_AA) ? SQ_E2 : SQ_IDLE;
          SQ_E2: st_q <= (at_b && data_i == CMD_55) ? SQ_E3 : SQ_IDLE;
          SQ_E3: begin
            st_q <= SQ_IDLE;
            if (data_i == CMD_SE) begin
              start_o   <= 1'b1;
              op_o      <= OP_SECT;
              op_addr_o <= addr_i[IW-1:0];
            end else if (at_a && data_i == CMD_CE && wp_ni) begin
              start_o <= 1'b1;
              op_o    <= OP_CHIP;
            end
          end
          default: st_q <= SQ_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/nor_busy_ctl.sv
module nor_busy_ctl
  import nor_flash_pkg::*;
#(
  parameter int IW         = 12,
  parameter int DEPTH      = 4096,
  parameter int SECT_WORDS = 2048,
  parameter int PROG_CYC   = 6,
  parameter int SECT_CYC   = 40,
  parameter int CHIP_CYC   = 80
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  op_e           op_i,
  input  logic [IW-1:0] addr_i,
  input  logic [15:0]   data_i,
  output logic          busy_o,
  output logic          erasing_o,
  output logic          mem_we_o,
  output logic          mem_and_o,
  output logic [IW-1:0] mem_addr_o,
  output logic [15:0]   mem_data_o
);

  localparam int MAX_AB = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAXC   = (MAX_AB > CHIP_CYC) ? MAX_AB : CHIP_CYC;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [IW-1:0] SECT_MASK = IW'(SECT_WORDS - 1);

  logic [CW-1:0] cnt_q, dur;
  logic          sweep_q;
  logic [IW-1:0] ptr_q, last_q;

  always_comb begin
    unique case (op_i)
      OP_PROG: dur = CW'(PROG_CYC);
      OP_SECT: dur = CW'(SECT_CYC);
      default: dur = CW'(CHIP_CYC);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      erasing_o <= 1'b0;
      sweep_q   <= 1'b0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      last_q    <= '0;
    end else if (start_i) begin
      busy_o    <= 1'b1;
      erasing_o <= (op_i != OP_PROG);
      sweep_q   <= (op_i != OP_PROG);
      cnt_q     <= dur;
      if (op_i == OP_CHIP) begin
        ptr_q  <= '0;
        last_q <= IW'(DEPTH - 1);
      end else begin
        ptr_q  <= addr_i & ~SECT_MASK;
        last_q <= addr_i | SECT_MASK;
      end
    end else if (busy_o) begin
      if (sweep_q) begin
        if (ptr_q == last_q) sweep_q <= 1'b0;
        else                 ptr_q   <= ptr_q + 1'b1;
      end
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (!sweep_q) begin
        busy_o    <= 1'b0;
        erasing_o <= 1'b0;
      end
    end
  end

  // program lands at start; erase writes one word per busy cycle
  assign mem_we_o   = (start_i && op_i == OP_PROG) || (busy_o && sweep_q);
  assign mem_and_o  = start_i;
  assign mem_addr_o = start_i ? addr_i : ptr_q;
  assign mem_data_o = start_i ? data_i : 16'hFFFF;

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
  parameter int DEPTH = 4096,
  parameter int IW    = 12
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          and_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [15:0]   wdata_i,
  input  logic          re_i,
  input  logic [IW-1:0] raddr_i,
  output logic [15:0]   rdata_o
);

  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= and_i ? (mem[waddr_i] & wdata_i) : wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd
  import nor_flash_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          SECT_BYTES = 4096,
  parameter int          NUM_SECT   = 2,
  parameter logic [15:0] DEV_ID     = 16'h2A61,
  parameter int          PROG_CYC   = 6,
  parameter int          SECT_CYC   = 40,
  parameter int          CHIP_CYC   = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              wp_ni,
  output logic [15:0]       rdata_o
);

  localparam int SECT_WORDS = SECT_BYTES / 2;
  localparam int DEPTH      = SECT_WORDS * NUM_SECT;
  localparam int IW         = $clog2(DEPTH);

  logic          start_q, id_enter, id_exit, id_mode_q;
  op_e           op_q;
  logic [IW-1:0] op_addr;
  logic [15:0]   op_data;
  logic          busy_q, erasing_q, busy_any, erasing_any, wr_ok;
  logic          mem_we, mem_and;
  logic [IW-1:0] mem_addr;
  logic [15:0]   mem_wdata, mem_rdata;
  logic          use_alt_q, t6_q, t2_q;
  logic [15:0]   alt_q;

  // busy is visible on the cycle right after the final command write
  assign busy_any    = busy_q | start_q;
  assign erasing_any = erasing_q | (start_q && op_q != OP_PROG);
  assign wr_ok       = we_i & ~busy_any;

  nor_cmd_seq #(.ADDR_W(ADDR_W), .IW(IW)) u_seq (
    .clk_i, .rst_ni,
    .wr_i       (wr_ok),
    .addr_i,
    .data_i     (wdata_i),
    .wp_ni,
    .start_o    (start_q),
    .op_o       (op_q),
    .op_addr_o  (op_addr),
    .op_data_o  (op_data),
    .id_enter_o (id_enter),
    .id_exit_o  (id_exit)
  );

  nor_busy_ctl #(
    .IW(IW), .DEPTH(DEPTH), .SECT_WORDS(SECT_WORDS),
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_busy (
    .clk_i, .rst_ni,
    .start_i    (start_q),
    .op_i       (op_q),
    .addr_i     (op_addr),
    .data_i     (op_data),
    .busy_o     (busy_q),
    .erasing_o  (erasing_q),
    .mem_we_o   (mem_we),
    .mem_and_o  (mem_and),
    .mem_addr_o (mem_addr),
    .mem_data_o (mem_wdata)
  );

  nor_cell_array #(.DEPTH(DEPTH), .IW(IW)) u_array (
    .clk_i,
    .we_i    (mem_we),
    .and_i   (mem_and),
    .waddr_i (mem_addr),
    .wdata_i (mem_wdata),
    .re_i,
    .raddr_i (addr_i[IW-1:0]),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       id_mode_q <= 1'b0;
    else if (id_enter) id_mode_q <= 1'b1;
    else if (id_exit)  id_mode_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_alt_q <= 1'b1;
      alt_q     <= '0;
      t6_q      <= 1'b0;
      t2_q      <= 1'b0;
    end else if (re_i) begin
      use_alt_q <= 1'b1;
      if (busy_any) begin
        t6_q <= ~t6_q;
        if (erasing_any) t2_q <= ~t2_q;
        alt_q <= {9'd0, ~t6_q, 3'd0, erasing_any ? ~t2_q : t2_q, 2'd0};
      end else if (id_mode_q && addr_i == '0) begin
        alt_q <= MFR_CODE;
      end else if (id_mode_q && addr_i == ADDR_W'(1)) begin
        alt_q <= DEV_ID;
      end else begin
        use_alt_q <= 1'b0;
      end
    end
  end

  assign rdata_o = use_alt_q ? alt_q : mem_rdata;

endmodule

// File: rtl/nor_flash_cmd_chk.sv
module nor_flash_cmd_chk
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wp_ni,
  input logic [15:0]       rdata_o,
  input logic              busy_any_i,
  input logic              erasing_any_i,
  input logic              start_i,
  input op_e               op_i,
  input logic              id_mode_i
);

  logic re_d, rd_busy_d, rd_erase_d, have_q, last6_q, last2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_d       <= 1'b0;
      rd_busy_d  <= 1'b0;
      rd_erase_d <= 1'b0;
      have_q     <= 1'b0;
      last6_q    <= 1'b0;
      last2_q    <= 1'b0;
    end else begin
      re_d       <= re_i;
      rd_busy_d  <= re_i & busy_any_i;
      rd_erase_d <= re_i & erasing_any_i;
      if (rd_busy_d) begin
        have_q  <= 1'b1;
        last6_q <= rdata_o[6];
        last2_q <= rdata_o[2];
      end else if (re_d) begin
        have_q <= 1'b0;
      end
    end
  end

  assert_status_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_d |-> (rdata_o & 16'hFFBB) == 16'h0000);

  assert_dq6_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_busy_d && have_q) |-> rdata_o[6] != last6_q);

  assert_dq2_erase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_erase_d && have_q) |-> rdata_o[2] != last2_q);

  assert_dq2_prog_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_busy_d && !rd_erase_d && have_q) |-> rdata_o[2] == last2_q);

  assert_no_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_any_i |=> !start_i);

  assert_wp_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_CHIP) |-> $past(wp_ni));

  assert_mfr_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !busy_any_i && id_mode_i && addr_i == '0) |=> rdata_o == MFR_CODE);

  assert_no_x_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !$isunknown(busy_any_i));

endmodule

bind nor_flash_cmd nor_flash_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wp_ni, .rdata_o,
  .busy_any_i    (busy_any),
  .erasing_any_i (erasing_any),
  .start_i       (start_q),
  .op_i          (op_q),
  .id_mode_i     (id_mode_q)
);

// File: tb/nor_flash_cmd_tb.sv
module nor_flash_cmd_tb;

  localparam int          DEPTH  = 4096;
  localparam logic [15:0] DEV_ID = 16'h2A61;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, wp_n = 1'b1;
  logic [15:0] addr = '0, wdata = '0, rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;

  nor_flash_cmd u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .wp_ni(wp_n), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic unlock();
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d);
    unlock();
    wr(16'h5555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase_prefix();
    unlock();
    wr(16'h5555, 16'h0080);
    unlock();
  endtask

  task automatic wait_ready(input string req);
    logic [15:0] a, b;
    bit ok;
    ok = 1'b0;
    rd(16'h0000, a);
    for (int n = 0; n < 6000; n++) begin
      rd(16'h0000, b);
      if (a === b) begin ok = 1'b1; break; end
      a = b;
    end
    if (!ok) chk({req, " ready"}, 16'h0001, 16'h0000);
  endtask

  task automatic verify_all(input string req);
    logic [15:0] v;
    int bad;
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(16'(i), v);
      if (v !== model[i]) begin
        if (bad < 4) $display("FAIL %s word %0h actual=%h expected=%h", req, i, v, model[i]);
        bad++;
      end
    end
    n_chk++;
    if (bad != 0) n_fail++;
  endtask

  function automatic logic [15:0] prog_val(input logic [15:0] old, input logic [15:0] d);
    return old & d;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] s1, s2, v;
    logic [15:0] pa [48];
    void'($urandom(32'd1207));

    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", rdata, 16'h0000);

    // whole-array erase, status right after the last write
    erase_prefix();
    wr(16'h5555, 16'h0010);
    rd(16'h0000, s1);
    chk("R7 erase status mask", s1 & 16'hFFBB, 16'h0000);
    rd(16'h0000, s2);
    chk("R7 erase dq6 flips", {15'd0, s2[6]}, {15'd0, ~s1[6]});
    chk("R8 erase dq2 flips", {15'd0, s2[2]}, {15'd0, ~s1[2]});
    wait_ready("R5");
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    verify_all("R5 array erase");

    // directed program, then AND behaviour
    prog(16'h0010, 16'h1234);
    rd(16'h0000, s1);
    chk("R7 prog status mask", s1 & 16'hFFBB, 16'h0000);
    rd(16'h0000, s2);
    chk("R7 prog dq6 flips", {15'd0, s2[6]}, {15'd0, ~s1[6]});
    chk("R8 prog dq2 steady", {15'd0, s2[2]}, {15'd0, s1[2]});
    wait_ready("R2");
    model[16'h0010] = prog_val(model[16'h0010], 16'h1234);
    rd(16'h0010, v);
    chk("R2 program word", v, 16'h1234);
    prog(16'h0010, 16'hFF0F);
    wait_ready("R3");
    model[16'h0010] = prog_val(model[16'h0010], 16'hFF0F);
    rd(16'h0010, v);
    chk("R3 program ANDs", v, 16'h1204);

    // random programs with readback
    for (int k = 0; k < 48; k++) begin
      pa[k] = 16'($urandom % DEPTH);
      s1 = 16'($urandom);
      prog(pa[k], s1);
      wait_ready("R2");
      model[pa[k]] = prog_val(model[pa[k]], s1);
    end
    for (int k = 0; k < 48; k++) begin
      rd(pa[k], v);
      chk("R3 random program", v, model[pa[k]]);
    end

    // broken sequences must not program
    unlock();
    wr(16'h1234, 16'h00A0);
    wr(16'h0020, 16'h0000);
    rd(16'h0020, v);
    chk("R10 wrong cmd address", v, model[16'h0020]);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0012);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, 16'h00A0);
    wr(16'h0021, 16'h0000);
    rd(16'h0021, v);
    chk("R10 wrong unlock data", v, model[16'h0021]);
    prog(16'h0021, 16'h00F0);
    wait_ready("R10");
    model[16'h0021] = prog_val(model[16'h0021], 16'h00F0);
    rd(16'h0021, v);
    chk("R10 restart works", v, model[16'h0021]);

    // write protect blocks array erase
    wp_n = 1'b0;
    erase_prefix();
    wr(16'h5555, 16'h0010);
    rd(16'h0010, v);
    chk("R6 erase blocked", v, model[16'h0010]);
    wp_n = 1'b1;

    // sector erase with a program attempted mid-erase
    erase_prefix();
    wr(16'h0923, 16'h0030);
    prog(16'h0010, 16'h0000);
    wait_ready("R4");
    for (int i = DEPTH / 2; i < DEPTH; i++) model[i] = 16'hFFFF;
    rd(16'h0010, v);
    chk("R9 write during busy ignored", v, model[16'h0010]);
    verify_all("R4 sector erase");

    // identification mode
    unlock();
    wr(16'h5555, 16'h0090);
    rd(16'h0000, v);
    chk("R11 id mfr", v, 16'h00BF);
    rd(16'h0001, v);
    chk("R11 id device", v, DEV_ID);
    unlock();
    wr(16'h5555, 16'h00F0);
    rd(16'h0000, v);
    chk("R11 exit to array", v, model[0]);
    rd(16'h0010, v);
    chk("R1 array read", v, model[16'h0010]);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule